// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block presents three stored BCD digits one at a time on a shared 4-bit data bus. Next to the bus it drives one active-low select line per digit, which a display driver uses to light the matching digit position. A scan position register rotates through the digits. Each rotation step is triggered by a scan tick. By default the tick comes from an internal prescaler that divides the system clock. Setting a mode input switches the tick source to an external scan input, which the block synchronizes and edge-detects.

Two inputs park the scanner: the chip reset `rst_n`, which is synchronous and active low, and the functional master-reset input `park`, which is active high. While parked, the scanner sits on the units digit, every select line is high and the prescaler is held at zero. On the first clock edge that no longer sees a park condition, the units select goes low. The digits are supplied already latched, as one packed vector. Field k occupies bits 4k+3..4k, and field 0 is the units digit.

Top module: `bcd_scan_mux`

## Requirements
- R1: `bcd_out` always equals the digit field at the current scan position. Position k reads bits 4k+3..4k of `digits`. This also holds while parked, when the position is 0.
- R2: When the previous clock edge saw neither `rst_n` low nor `park` high, exactly one bit of `sel_n` is low, and that bit is `sel_n[k]` for scan position k.
- R3: A clock edge that samples `rst_n` low or `park` high sets the position to 0 (units) and drives all of `sel_n` high from that edge on.
- R4: The scan position follows the order 0, 1, 2, 0, and moves one step per scan tick.
- R5: With `use_ext` = 0, the first advance after a park ends happens on the PRESCALE-th clock edge, counting the first edge that sees no park condition as edge 1. Further advances follow every PRESCALE edges.
- R6: With `use_ext` = 1, a low-to-high change of `ext_scan` that is first sampled at edge k advances the scanner at edge k+SYNC_STAGES. Falling edges and steady levels never advance it.
- R7: While parked, the scanner never advances and the prescaler stays at zero.
- R8: `bcd_out` and `sel_n` update on the same clock edge, so the data on the bus always belongs to the digit whose select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| park | input | 1 | Active-high master reset: holds the scanner on digit 0 with all selects off |
| use_ext | input | 1 | 0 = internal prescaler tick, 1 = external scan input |
| ext_scan | input | 1 | Asynchronous external scan clock; each rising edge is one tick |
| digits | input | 12 | Three latched BCD digits, units in bits 3..0 |
| bcd_out | output | 4 | Active-high BCD value of the selected digit |
| sel_n | output | 3 | Active-low digit selects, bit 0 = units |

## Verification
Some properties are checked by assertions on every cycle:
- the scan position stays in range;
- it moves by exactly one wrapping step on a tick and holds otherwise;
- a park returns it to 0 and clears the prescaler;
- an edge-detected external tick is never two cycles long;
- one select is low after a clean cycle, all selects are high after a park;
- the units select always comes with the units data.

Other behaviour only the bench's scenarios can show, because it compares the ports against an independent cycle model: the exact tick spacing in internal mode, the synchronizer latency, the absence of advances on falling external edges, and the restart timing after a park.

// File: rtl/scan_pkg.sv
// Shared definitions for the BCD digit scanner.
package scan_pkg;
    // Selects where the scan advance tick is generated.
    typedef enum logic {
        TICK_INTERNAL = 1'b0,
        TICK_EXTERNAL = 1'b1
    } tick_src_e;
endpackage

// File: rtl/scan_tick_gen.sv
// Produces the one-cycle scan advance tick.
// Internal source: a free-running divide-by-PRESCALE counter.
// External source: a synchronized, rising-edge detected input.
// Assumes PRESCALE >= 2 and SYNC_STAGES >= 2. While parked the counter
// is held at zero and no tick leaves the block.
module scan_tick_gen
    import scan_pkg::*;
#(
    parameter int PRESCALE    = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      park,
    input  tick_src_e src,
    input  logic      ext_scan,
    output logic      tick
);
    localparam int               CNT_W    = $clog2(PRESCALE);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0]       cnt_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   int_tick;
    logic                   ext_tick;

    // Prescaler: counts 0..PRESCALE-1, held at zero while parked.
    always_ff @(posedge clk) begin
        if (!rst_n || park)
            cnt_q <= '0;
        else if (cnt_q == CNT_LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Synchronizer chain for the asynchronous external scan input.
    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ext_scan;
                end
            end else begin : g_next
                // Later stages pass the value along.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    // Keeps the last synchronized level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Tick selection, gated off while parked.
    always_comb begin
        int_tick = (cnt_q == CNT_LAST);
        ext_tick = sync_q[SYNC_STAGES-1] & ~prev_q;
        tick     = ((src == TICK_EXTERNAL) ? ext_tick : int_tick) & ~park;
    end

    // R7
    prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park |=> (cnt_q == '0));

    // R6
    ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |=> !ext_tick);
endmodule

// File: rtl/digit_ring.sv
// Scan position register and blanking flag.
// The position rotates 0..NUM_DIGITS-1 by one step per tick. A park or a
// reset forces position 0 with blanking on. Blanking clears on the first
// edge that sees no park condition. Assumes NUM_DIGITS >= 2.
module digit_ring #(
    parameter int NUM_DIGITS = 3,
    localparam int POS_W     = $clog2(NUM_DIGITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park,
    input  logic             tick,
    output logic [POS_W-1:0] pos,
    output logic             blank
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_DIGITS - 1);

    logic [POS_W-1:0] pos_q;
    logic             blank_q;

    // Position update: home on park, wrap-around step on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || park)
            pos_q <= '0;
        else if (tick)
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
    end

    // Blanking follows the park condition with one register of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) blank_q <= 1'b1;
        else        blank_q <= park;
    end

    assign pos   = pos_q;
    assign blank = blank_q;

    // R4
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST_POS);

    // R4
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !park) |=> (pos_q == (($past(pos_q) == LAST_POS) ? '0
                                        : $past(pos_q) + POS_W'(1))));

    // R7
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !park) |=> $stable(pos_q));

    // R3
    park_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park |=> (pos_q == '0 && blank_q));
endmodule

// File: rtl/digit_present.sv
// Output stage: routes the digit at the scan position onto the shared
// bus and decodes the position into active-low selects. Purely
// combinational, so the data and the selects move on the same edge.
module digit_present #(
    parameter int NUM_DIGITS = 3,
    parameter int DIGIT_W    = 4,
    localparam int POS_W     = $clog2(NUM_DIGITS)
) (
    input  logic [POS_W-1:0]             pos,
    input  logic                         blank,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits,
    output logic [DIGIT_W-1:0]           bcd_out,
    output logic [NUM_DIGITS-1:0]        sel_n
);
    // Data multiplexer: picks the field at the scan position.
    always_comb begin
        bcd_out = '0;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (pos == POS_W'(k))
                bcd_out = digits[k*DIGIT_W +: DIGIT_W];
        end
    end

    // One active-low select per digit, all forced high while blanked.
    genvar k;
    generate
        for (k = 0; k < NUM_DIGITS; k++) begin : g_sel
            assign sel_n[k] = blank | (pos != POS_W'(k));
        end
    endgenerate
endmodule

// File: rtl/bcd_scan_mux.sv
// Top of the multiplexed BCD digit scanner: tick generator, scan
// position ring and output stage. Assumes the digits are already
// latched and that ext_scan is asynchronous to clk.
module bcd_scan_mux
    import scan_pkg::*;
#(
    parameter int NUM_DIGITS  = 3,
    parameter int DIGIT_W     = 4,
    parameter int PRESCALE    = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          park,
    input  logic                          use_ext,
    input  logic                          ext_scan,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits,
    output logic [DIGIT_W-1:0]            bcd_out,
    output logic [NUM_DIGITS-1:0]         sel_n
);
    localparam int POS_W = $clog2(NUM_DIGITS);

    tick_src_e        src;
    logic             tick;
    logic [POS_W-1:0] pos;
    logic             blank;

    assign src = use_ext ? TICK_EXTERNAL : TICK_INTERNAL;

    scan_tick_gen #(
        .PRESCALE    (PRESCALE),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .park     (park),
        .src      (src),
        .ext_scan (ext_scan),
        .tick     (tick)
    );

    digit_ring #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .park  (park),
        .tick  (tick),
        .pos   (pos),
        .blank (blank)
    );

    digit_present #(
        .NUM_DIGITS (NUM_DIGITS),
        .DIGIT_W    (DIGIT_W)
    ) u_out (
        .pos     (pos),
        .blank   (blank),
        .digits  (digits),
        .bcd_out (bcd_out),
        .sel_n   (sel_n)
    );

    // R3
    parked_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(park) |-> (&sel_n));

    // R2
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(park) && $past(rst_n)) |-> ($countones(~sel_n) == 1));

    // R8
    units_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n[0] |-> (bcd_out == digits[DIGIT_W-1:0]));
endmodule

// File: tb/tb_bcd_scan_mux.sv
`timescale 1ns/1ps
module tb_bcd_scan_mux;
    localparam int ND  = 3;
    localparam int DW  = 4;
    localparam int PS  = 5;
    localparam int SS  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            park = 1'b0;
    logic            use_ext = 1'b0;
    logic            ext_scan = 1'b0;
    logic [ND*DW-1:0] digits = '0;
    logic [DW-1:0]   bcd_out;
    logic [ND-1:0]   sel_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state.
    int       m_cnt = 0;
    int       m_pos = 0;
    bit       m_blank = 1'b1;
    bit [SS:0] m_sh = '0;

    bcd_scan_mux #(.NUM_DIGITS(ND), .DIGIT_W(DW), .PRESCALE(PS),
                   .SYNC_STAGES(SS)) dut (
        .clk(clk), .rst_n(rst_n), .park(park), .use_ext(use_ext),
        .ext_scan(ext_scan), .digits(digits), .bcd_out(bcd_out),
        .sel_n(sel_n));

    always #2.5 clk = ~clk;

    // Advance the model by one clock edge using the held inputs (R3-R7).
    task automatic model_edge();
        bit parked = !rst_n || park;
        bit itick  = (m_cnt == PS - 1);
        bit etick  = m_sh[SS-1] && !m_sh[SS];
        bit tck    = (use_ext ? etick : itick) && !parked;
        if (!rst_n) m_sh = '0;
        else        m_sh = {m_sh[SS-1:0], ext_scan};
        m_cnt   = parked ? 0 : ((m_cnt == PS - 1) ? 0 : m_cnt + 1);
        if (parked)   m_pos = 0;
        else if (tck) m_pos = (m_pos == ND - 1) ? 0 : m_pos + 1;
        m_blank = parked;
    endtask

    function automatic logic [ND-1:0] exp_sel();
        logic [ND-1:0] e = '1;
        if (!m_blank) e[m_pos] = 1'b0;
        return e;
    endfunction

    function automatic logic [DW-1:0] exp_bcd();
        return digits[m_pos*DW +: DW];
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model (called away from the edge).
    task automatic check_all();
        string st = m_blank ? "R3 R7" : (use_ext ? "R2 R4 R6" : "R2 R4 R5");
        check(st, 16'(sel_n), 16'(exp_sel()));
        check("R1", 16'(bcd_out), 16'(exp_bcd()));
        for (int k = 0; k < ND; k++)
            if (!sel_n[k]) check("R8", 16'(bcd_out), 16'(digits[k*DW +: DW]));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd7321);
        @(negedge clk);
        step(); step();
        check("R3", 16'(sel_n), 16'h7);
        rst_n = 1'b1;
        digits = 12'h951;
        // Directed: internal-mode restart timing after reset (R5).
        for (int i = 0; i < 3 * PS + 2; i++) step();
        // Directed: long park, all-nines digits, then release (R7, R3).
        park = 1'b1; digits = 12'h999;
        for (int i = 0; i < 2 * PS; i++) step();
        park = 1'b0;
        for (int i = 0; i < 2 * PS; i++) step();
        // Directed: external mode, slow square wave (R6).
        use_ext = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (i % 4 == 0) ext_scan = ~ext_scan;
            step();
        end
        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            if (i < 1300)      use_ext = 1'b0;
            else if (i < 2600) use_ext = 1'b1;
            else if ($urandom_range(99) < 2) use_ext = ~use_ext;
            park     = ($urandom_range(99) < 3);
            rst_n    = ($urandom_range(199) != 0);
            if ($urandom_range(99) < 30) ext_scan = ~ext_scan;
            for (int k = 0; k < ND; k++)
                digits[k*DW +: DW] = DW'($urandom_range(9));
            step();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule